// File: doc/BRIEF.md
# System control register file

This block is a bank of 32-bit board-control words behind a simple single-cycle, word-aligned bus with a 4 KB address window. A write to the first configuration word moves a remap line. A write to the second word lights a row of LEDs. Other words hold fixed identification constants that the integrator sets by parameter. One word reports the lock state of eight clock loops together with a software-writable mask, and a single summary bit says whether every loop that the mask selects is locked.

A `VARIANT` parameter decides which optional configuration words exist. An access to an offset that is absent in the chosen variant, unmapped, misaligned, or a write to a read-only word, does nothing to the register state. It raises a one-cycle `bad_access_o` pulse. Read data is registered, so it appears on the clock edge after the read is presented and holds until the next read.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset the control word (0x000) holds `CFG0_RST`, the LED word (0x004) and the optional words (0x008, 0x014, 0x018) hold zero, the lock mask holds 0xFF, `remap_o` equals `CFG0_RST[0]`, and `bus_rdata` and `bad_access_o` are zero.
- R2: A write to 0x000 stores all 32 bits, and from the next cycle `remap_o` equals bit 0 of the stored value.
- R3: A write to 0x004 stores all 32 bits, and from the next cycle `led_o[i]` equals bit i of the stored value.
- R4: Offsets 0x008 and 0x014 are read/write words when `VARIANT` is 1 or 2. Offset 0x018 is a read/write word only when `VARIANT` is 1. In any other case these offsets behave as unmapped (R8).
- R5: 0x00C reads as zero. 0x010, 0xFF8 and 0xFFC read as `CFG4_VAL`, `AID_VAL` and `ID_VAL`. A write to any of these four changes nothing and pulses `bad_access_o`.
- R6: The lock word at 0x100 reads as {mask[7:0], loop_locked_i[7:0], 15 zero bits, all_ok}. A write changes only the mask, which is taken from `bus_wdata[31:24]`.
- R7: all_ok is 1 exactly when, for every loop n from 0 to 7, loop n is locked or mask bit n is 0.
- R8: A read of an unmapped offset returns zero. A write to an unmapped offset changes no state. Either access sets `bad_access_o` for the following cycle only.
- R9: `bus_rdata` takes the addressed word on the clock edge after a read is presented, and holds its value in cycles without a read.
- R10: An address whose bits [1:0] are not zero is treated as unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| remap_o | output | 1 | Remap control line |
| led_o | output | NUM_LEDS | LED drive lines |
| loop_locked_i | input | 8 | Per-loop lock flags |
| bad_access_o | output | 1 | One-cycle pulse after a rejected access |

## Verification
The bench runs with `VARIANT` 2, so a single build covers both a present optional word (0x008, 0x014) and an absent one (0x018). Distinct data patterns, such as alternating nibbles, inverted halves and a value that differs only in bit 0, separate a correct remap or LED mapping from a swapped bit or a stuck bit. The lock word is tried with mask and lock combinations chosen so that one masked-out unlocked loop, one unmasked unlocked loop, and all loops unlocked under an empty mask each give a different summary bit. Back-to-back rejected accesses, writes to constant words, and misaligned addresses check that the error pulse follows each access and that no stored word changes.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  typedef enum logic [3:0] {
    RS_NONE, RS_CTRL, RS_LEDS, RS_OPT_A, RS_SWITCH, RS_CONST4,
    RS_OPT_B, RS_OPT_C, RS_LOCK, RS_AUXID, RS_MAINID
  } reg_sel_e;

  // word indexes (byte offset / 4)
  localparam int W_CTRL   = 'h000;
  localparam int W_LEDS   = 'h001;
  localparam int W_OPT_A  = 'h002;
  localparam int W_SWITCH = 'h003;
  localparam int W_CONST4 = 'h004;
  localparam int W_OPT_B  = 'h005;
  localparam int W_OPT_C  = 'h006;
  localparam int W_LOCK   = 'h040;
  localparam int W_AUXID  = 'h3FE;
  localparam int W_MAINID = 'h3FF;

  localparam int LOOPS = 8;

  function automatic logic reg_present(input int variant, input reg_sel_e s);
    case (s)
      RS_NONE:         return 1'b0;
      RS_OPT_A, RS_OPT_B: return (variant == 1) || (variant == 2);
      RS_OPT_C:        return variant == 1;
      default:         return 1'b1;
    endcase
  endfunction

  function automatic logic reg_writable(input reg_sel_e s);
    case (s)
      RS_CTRL, RS_LEDS, RS_OPT_A, RS_OPT_B, RS_OPT_C, RS_LOCK: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // summary bit: every loop either locked or masked out
  function automatic logic loops_all_ok(input logic [LOOPS-1:0] mask,
                                        input logic [LOOPS-1:0] locked);
    logic ok;
    ok = 1'b1;
    for (int n = 0; n < LOOPS; n++) begin
      ok = ok & (locked[n] | ~mask[n]);
    end
    return ok;
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int VARIANT = 1,
  parameter int ADDR_W  = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel,
  output logic              mapped,
  output logic              writable
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;
  reg_sel_e          raw;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    case (int'(word))
      W_CTRL:   raw = RS_CTRL;
      W_LEDS:   raw = RS_LEDS;
      W_OPT_A:  raw = RS_OPT_A;
      W_SWITCH: raw = RS_SWITCH;
      W_CONST4: raw = RS_CONST4;
      W_OPT_B:  raw = RS_OPT_B;
      W_OPT_C:  raw = RS_OPT_C;
      W_LOCK:   raw = RS_LOCK;
      W_AUXID:  raw = RS_AUXID;
      W_MAINID: raw = RS_MAINID;
      default:  raw = RS_NONE;
    endcase
  end

  assign mapped   = aligned && reg_present(VARIANT, raw);
  assign sel      = mapped ? raw : RS_NONE;
  assign writable = mapped && reg_writable(raw);

endmodule

// File: rtl/sysctl_cfg_word.sv
module sysctl_cfg_word #(
  parameter bit          PRESENT = 1'b1,
  parameter logic [31:0] RST_VAL = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [31:0] d,
  output logic [31:0] q
);
  generate
    if (PRESENT) begin : g_flop
      logic [31:0] q_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q_r <= RST_VAL;
        else if (we) q_r <= d;
      end
      assign q = q_r;
    end else begin : g_absent
      assign q = 32'h0;
    end
  endgenerate

endmodule

// File: rtl/sysctl_lockstat.sv
module sysctl_lockstat
  import sysctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [7:0]       mask_d,
  input  logic [LOOPS-1:0] locked_i,
  output logic [31:0]      status_word
);
  logic [LOOPS-1:0] mask_q;
  logic             all_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mask_q <= '1;
    else if (we) mask_q <= mask_d;
  end

  assign all_ok      = loops_all_ok(mask_q, locked_i);
  assign status_word = {mask_q, locked_i, 15'h0, all_ok};

  assert_mask_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mask_q));

  assert_mask_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (status_word[31:24] == $past(mask_d)));

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int          VARIANT  = 1,
  parameter int          NUM_LEDS = 8,
  parameter int          ADDR_W   = 12,
  parameter logic [31:0] CFG0_RST = 32'h0,
  parameter logic [31:0] CFG4_VAL = 32'h0,
  parameter logic [31:0] AID_VAL  = 32'h0,
  parameter logic [31:0] ID_VAL   = 32'h0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                remap_o,
  output logic [NUM_LEDS-1:0] led_o,
  input  logic [7:0]          loop_locked_i,
  output logic                bad_access_o
);
  localparam bit HAS_A = reg_present(VARIANT, RS_OPT_A);
  localparam bit HAS_B = reg_present(VARIANT, RS_OPT_B);
  localparam bit HAS_C = reg_present(VARIANT, RS_OPT_C);

  reg_sel_e dec_sel;
  logic     dec_mapped, dec_writable;

  sysctl_decode #(.VARIANT(VARIANT), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .sel(dec_sel), .mapped(dec_mapped), .writable(dec_writable)
  );

  // named bus events
  logic rd_ev, wr_ev, bad_ev, store_ev;
  assign rd_ev    = bus_sel && !bus_wr;
  assign wr_ev    = bus_sel && bus_wr;
  assign bad_ev   = bus_sel && (!dec_mapped || (bus_wr && !dec_writable));
  assign store_ev = wr_ev && dec_writable;

  logic [31:0] ctrl_q, leds_q, opt_a_q, opt_b_q, opt_c_q, lock_word;

  sysctl_cfg_word #(.PRESENT(1'b1), .RST_VAL(CFG0_RST)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(store_ev && dec_sel == RS_CTRL),
    .d(bus_wdata), .q(ctrl_q));
  sysctl_cfg_word #(.PRESENT(1'b1), .RST_VAL(32'h0)) u_leds (
    .clk(clk), .rst_n(rst_n), .we(store_ev && dec_sel == RS_LEDS),
    .d(bus_wdata), .q(leds_q));
  sysctl_cfg_word #(.PRESENT(HAS_A), .RST_VAL(32'h0)) u_opt_a (
    .clk(clk), .rst_n(rst_n), .we(store_ev && dec_sel == RS_OPT_A),
    .d(bus_wdata), .q(opt_a_q));
  sysctl_cfg_word #(.PRESENT(HAS_B), .RST_VAL(32'h0)) u_opt_b (
    .clk(clk), .rst_n(rst_n), .we(store_ev && dec_sel == RS_OPT_B),
    .d(bus_wdata), .q(opt_b_q));
  sysctl_cfg_word #(.PRESENT(HAS_C), .RST_VAL(32'h0)) u_opt_c (
    .clk(clk), .rst_n(rst_n), .we(store_ev && dec_sel == RS_OPT_C),
    .d(bus_wdata), .q(opt_c_q));

  sysctl_lockstat u_lock (
    .clk(clk), .rst_n(rst_n), .we(store_ev && dec_sel == RS_LOCK),
    .mask_d(bus_wdata[31:24]), .locked_i(loop_locked_i), .status_word(lock_word));

  logic [31:0] rd_mux;
  always_comb begin
    case (dec_sel)
      RS_CTRL:   rd_mux = ctrl_q;
      RS_LEDS:   rd_mux = leds_q;
      RS_OPT_A:  rd_mux = opt_a_q;
      RS_SWITCH: rd_mux = 32'h0;
      RS_CONST4: rd_mux = CFG4_VAL;
      RS_OPT_B:  rd_mux = opt_b_q;
      RS_OPT_C:  rd_mux = opt_c_q;
      RS_LOCK:   rd_mux = lock_word;
      RS_AUXID:  rd_mux = AID_VAL;
      RS_MAINID: rd_mux = ID_VAL;
      default:   rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata    <= 32'h0;
      bad_access_o <= 1'b0;
    end else begin
      if (rd_ev) bus_rdata <= rd_mux;
      bad_access_o <= bad_ev;
    end
  end

  assign remap_o = ctrl_q[0];
  assign led_o   = leds_q[NUM_LEDS-1:0];

  // ---------------- assertions ----------------
  assert_remap_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && bus_addr == '0) |=> (remap_o == $past(bus_wdata[0])));

  assert_led_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && int'(bus_addr) == 4) |=> (led_o == $past(bus_wdata[NUM_LEDS-1:0])));

  assert_absent_flagged_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && int'(bus_addr) == 'h18 && VARIANT != 1) |=> bad_access_o);

  assert_const_write_flagged_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ev && int'(bus_addr) == 'hFFC) |=> bad_access_o);

  assert_bad_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ev && !dec_mapped) |=> (bus_rdata == 32'h0));

  assert_bad_only_after_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> !bad_access_o);

  assert_rdata_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ev |=> $stable(bus_rdata));

  assert_misaligned_flagged_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr[1:0] != 2'b00) |=> bad_access_o);

endmodule

// File: tb/sysctl_regfile_test.sv
module sysctl_regfile_test;
  localparam int CLK_PERIOD = 10;
  localparam int VAR = 2;
  localparam logic [31:0] C0R = 32'h0000_0001;
  localparam logic [31:0] C4V = 32'h0004_1234;
  localparam logic [31:0] AIDV = 32'hA1D0_0007;
  localparam logic [31:0] IDV = 32'h4152_5470;

  logic clk = 0, rst_n = 0, bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic remap_o, bad_access_o;
  logic [7:0] led_o, locked = 8'hFF;

  int compared = 0, mismatched = 0;

  sysctl_regfile #(.VARIANT(VAR), .NUM_LEDS(8), .ADDR_W(12), .CFG0_RST(C0R),
                   .CFG4_VAL(C4V), .AID_VAL(AIDV), .ID_VAL(IDV)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .remap_o(remap_o), .led_o(led_o), .loop_locked_i(locked),
    .bad_access_o(bad_access_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural model state
  logic [31:0] m_w0 = C0R, m_w1 = 0, m_w2 = 0, m_w5 = 0, m_w6 = 0, m_rd = 0;
  logic [7:0]  m_mask = 8'hFF;
  logic        m_bad = 0;

  function automatic bit exists(input logic [11:0] a);
    int w = int'(a) / 4;
    if (a[1:0] != 0) return 0;
    if (w == 2 || w == 5) return VAR == 1 || VAR == 2;
    if (w == 6) return VAR == 1;
    return (w <= 4) || w == 64 || w == 1022 || w == 1023;
  endfunction

  function automatic bit can_store(input logic [11:0] a);
    int w = int'(a) / 4;
    return exists(a) && (w == 0 || w == 1 || w == 2 || w == 5 || w == 6 || w == 64);
  endfunction

  function automatic logic [31:0] model_read(input logic [11:0] a);
    int w = int'(a) / 4;
    bit ok = ((locked | ~m_mask) == 8'hFF);
    if (!exists(a)) return 0;
    if (w == 0) return m_w0;
    if (w == 1) return m_w1;
    if (w == 2) return m_w2;
    if (w == 4) return C4V;
    if (w == 5) return m_w5;
    if (w == 6) return m_w6;
    if (w == 64) return {m_mask, locked, 15'd0, ok};
    if (w == 1022) return AIDV;
    if (w == 1023) return IDV;
    return 0;
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit sel, input bit wr, input logic [11:0] a,
                      input logic [31:0] d, input string req);
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    m_bad = sel && (!exists(a) || (wr && !can_store(a)));
    if (sel && !wr) m_rd = model_read(a);
    if (sel && wr && can_store(a)) begin
      case (int'(a) / 4)
        0: m_w0 = d;
        1: m_w1 = d;
        2: m_w2 = d;
        5: m_w5 = d;
        6: m_w6 = d;
        64: m_mask = d[31:24];
        default: ;
      endcase
    end
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    check(bus_rdata, m_rd, req);
    check({31'd0, remap_o}, {31'd0, m_w0[0]}, "R2");
    check({24'd0, led_o}, {24'd0, m_w1[7:0]}, "R3");
    check({31'd0, bad_access_o}, {31'd0, m_bad}, "R8");
  endtask

  task automatic rd(input logic [11:0] a, input string req);
    step(1, 0, a, 32'h0, req);
  endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string req);
    step(1, 1, a, d, req);
  endtask
  task automatic idle(input string req);
    step(0, 0, 12'h0, 32'h0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    idle("R1");
    rd(12'h000, "R1"); rd(12'h004, "R1"); rd(12'h008, "R1");
    rd(12'h014, "R1"); rd(12'h100, "R1");
    // R2 control word and remap
    wr(12'h000, 32'hDEAD_BEE0, "R2"); rd(12'h000, "R2");
    wr(12'h000, 32'h0000_0001, "R2"); wr(12'h000, 32'hFFFF_FFFE, "R2");
    rd(12'h000, "R2");
    // R3 LEDs
    wr(12'h004, 32'h0000_00A5, "R3"); wr(12'h004, 32'h1234_565A, "R3");
    rd(12'h004, "R3"); wr(12'h004, 32'h0000_0080, "R3");
    // R4 optional words
    wr(12'h008, 32'hCAFE_0001, "R4"); wr(12'h014, 32'h0BAD_F00D, "R4");
    rd(12'h008, "R4"); rd(12'h014, "R4");
    wr(12'h018, 32'h5555_AAAA, "R4"); rd(12'h018, "R4");
    // R5 constant words
    rd(12'h00C, "R5"); rd(12'h010, "R5"); rd(12'hFF8, "R5"); rd(12'hFFC, "R5");
    wr(12'h00C, 32'hFFFF_FFFF, "R5"); wr(12'h010, 32'h1111_1111, "R5");
    wr(12'hFF8, 32'h2222_2222, "R5"); wr(12'hFFC, 32'h3333_3333, "R5");
    rd(12'h00C, "R5"); rd(12'h010, "R5"); rd(12'hFF8, "R5"); rd(12'hFFC, "R5");
    // R6 lock word layout and mask write
    wr(12'h100, 32'h1234_5678, "R6"); rd(12'h100, "R6");
    locked = 8'h3C; rd(12'h100, "R6");
    // R7 summary bit cases
    wr(12'h100, 32'h0000_0000, "R7"); locked = 8'h00; rd(12'h100, "R7");
    wr(12'h100, 32'hFF00_0000, "R7"); locked = 8'hFE; rd(12'h100, "R7");
    wr(12'h100, 32'h0F00_0000, "R7"); locked = 8'h0F; rd(12'h100, "R7");
    wr(12'h100, 32'h1000_0000, "R7"); locked = 8'hEF; rd(12'h100, "R7");
    locked = 8'h10; rd(12'h100, "R7");
    // R8 unmapped accesses, back to back
    rd(12'h004, "R8"); rd(12'h200, "R8"); wr(12'h104, 32'hFFFF_FFFF, "R8");
    rd(12'h104, "R8"); idle("R8"); rd(12'h000, "R8");
    // R9 hold across idle and writes
    rd(12'h008, "R9"); idle("R9"); wr(12'h008, 32'h7777_0000, "R9");
    idle("R9"); rd(12'h008, "R9");
    // R10 misaligned
    wr(12'h001, 32'h0000_0000, "R10"); rd(12'h002, "R10");
    wr(12'h007, 32'h0000_0000, "R10"); rd(12'h004, "R10"); rd(12'h000, "R10");
    idle("R1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule